// File: doc/BRIEF.md
# Coarse/Fine Triggered Delay Generator

This block emits a delayed output pulse after each accepted trigger. The programmed delay is in 100 ps steps. The block splits it into two parts. The coarse part is a whole number of logic clock periods, counted by a down-counter. The fine part is the remainder below one clock period. It leaves the block as a code from 0 to 99, which drives an external analog ramp and comparator stage. The block does not contain that stage.

The trigger comes either from an external input or from an internal periodic timer. The external path passes through a synchroniser and an edge detector. An external time-measurement stage measures the external trigger's position inside the clock period and supplies it as a phase code. The block adds that code to the fine part, and a carry past 99 lengthens the coarse count by one period. The random trigger-to-clock offset therefore cancels out of the final output timing. An embedded processor writes the delay, pulse width, timer period and source selection through a simple register write port.

The running sequence works from values captured when the trigger is accepted. A register write made during a sequence applies from the next accepted trigger.

Top module: `dly_pulse_gen`

## Requirements
- R1: Register writes use `wr_en`, `wr_addr` and `wr_data`. Address 0 is the delay (bits 23:0, in 100 ps steps). Address 1 is the pulse width (bits 15:0, in clock cycles). Address 2 is the self-trigger period (bits 31:0, in clock cycles). Address 3 is control, where bit 0 selects the source (0 = external, 1 = internal timer). After reset the registers hold delay 0, width 1, period 0 and external source, and `busy`, `pulse_out` and `fine_code` are all 0.
- R2: When the external source is selected and idle, a rising edge on `trig_ext` is accepted after a two-stage synchroniser. `busy` rises, and `pulse_out` rises C+1 cycles after `busy` rises. Here C = floor(T/100), with T = delay + effective phase.
- R3: `fine_code` equals T mod 100, and it takes that value in the same cycle that `busy` rises.
- R4: When the programmed fine part plus the phase reaches 100 or more, `fine_code` wraps by 100 and the coarse count grows by exactly one cycle.
- R5: `pulse_out` stays high for the programmed width in cycles. A programmed width of 0 acts as 1. `busy` falls in the cycle after the pulse ends.
- R6: A trigger that arrives while `busy` is high is ignored. It neither restarts the count nor changes `fine_code`.
- R7: With the internal source selected, a trigger is generated every `period` cycles and uses an effective phase of 0. The unselected source has no effect.
- R8: A self-trigger period of 0 disables the internal timer.
- R9: Writes to delay or width made while `busy` is high leave the current sequence unchanged and take effect at the next accepted trigger.
- R10: A `trig_phase` code above 99 is treated as 99.
- R11: `fine_code` stays constant while `pulse_out` is high and afterwards, until the next accepted trigger.
- R12: A delay of 10,000,000 steps (1 ms) is supported and gives a coarse count of 100,000 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock (10 ns period in the target system) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 32 | Register write data |
| trig_ext | input | 1 | External trigger, asynchronous |
| trig_phase | input | 7 | Measured trigger phase inside the clock period, 100 ps units |
| busy | output | 1 | High from trigger acceptance until the pulse ends |
| pulse_out | output | 1 | Delayed output pulse |
| fine_code | output | 7 | Sub-period delay code for the analog ramp, 0 to 99 |

## Verification
The bench targets the carry boundary, where fine part plus phase passes 99. A design that dropped the carry would come out a full clock period early, and a missing wrap would produce a fine code above 99. It also drives a zero coarse count, a zero width, an out-of-range phase code, and a 1 ms delay; off-by-one counters, stuck pulses and a truncated delay register all show up there as wrong cycle counts. It re-triggers and rewrites registers in the middle of a sequence. A design without snapshotting or busy gating would restart the count, move `fine_code` under a live pulse, or emit a second pulse. Finally it checks that the internal timer honours its period and a zero period, and that the unselected source is fully masked.

// File: rtl/dpg_pkg.sv
package dpg_pkg;
  localparam int REG_ADDR_W = 2;

  localparam logic [REG_ADDR_W-1:0] REG_DELAY  = 2'd0;
  localparam logic [REG_ADDR_W-1:0] REG_WIDTH  = 2'd1;
  localparam logic [REG_ADDR_W-1:0] REG_PERIOD = 2'd2;
  localparam logic [REG_ADDR_W-1:0] REG_CTRL   = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_PULSE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/dpg_regs.sv
module dpg_regs
  import dpg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int DELAY_W  = 24,
  parameter int STEPS    = 100,
  parameter int FINE_W   = 7,
  parameter int WIDTH_W  = 16,
  parameter int PERIOD_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [DELAY_W-1:0]    crs_o,
  output logic [FINE_W-1:0]     fin_o,
  output logic [WIDTH_W-1:0]    width_o,
  output logic [PERIOD_W-1:0]   period_o,
  output logic                  src_self_o
);
  localparam logic [DELAY_W-1:0] STEPS_D = DELAY_W'(STEPS);

  logic [DELAY_W-1:0]  crs_q, crs_d;
  logic [FINE_W-1:0]   fin_q, fin_d;
  logic [WIDTH_W-1:0]  width_q, width_d;
  logic [PERIOD_W-1:0] period_q, period_d;
  logic                src_q, src_d;

  logic                en_delay, en_width, en_period, en_ctrl;
  logic [DELAY_W-1:0]  wr_delay, wr_rem;
  logic [WIDTH_W-1:0]  wr_width;

  assign wr_delay = wr_data[DELAY_W-1:0];
  assign wr_width = wr_data[WIDTH_W-1:0];
  assign wr_rem   = wr_delay % STEPS_D;

  always_comb begin
    en_delay  = wr_en && (wr_addr == REG_DELAY);
    en_width  = wr_en && (wr_addr == REG_WIDTH);
    en_period = wr_en && (wr_addr == REG_PERIOD);
    en_ctrl   = wr_en && (wr_addr == REG_CTRL);

    crs_d    = crs_q;
    fin_d    = fin_q;
    width_d  = width_q;
    period_d = period_q;
    src_d    = src_q;

    if (en_delay) begin
      crs_d = wr_delay / STEPS_D;
      fin_d = wr_rem[FINE_W-1:0];
    end
    if (en_width) begin
      width_d = (wr_width == '0) ? WIDTH_W'(1) : wr_width;
    end
    if (en_period) begin
      period_d = wr_data[PERIOD_W-1:0];
    end
    if (en_ctrl) begin
      src_d = wr_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crs_q    <= '0;
      fin_q    <= '0;
      width_q  <= WIDTH_W'(1);
      period_q <= '0;
      src_q    <= 1'b0;
    end else begin
      crs_q    <= crs_d;
      fin_q    <= fin_d;
      width_q  <= width_d;
      period_q <= period_d;
      src_q    <= src_d;
    end
  end

  assign crs_o      = crs_q;
  assign fin_o      = fin_q;
  assign width_o    = width_q;
  assign period_o   = period_q;
  assign src_self_o = src_q;

  AST_FINE_REG_RANGE: assert property (@(posedge clk) disable iff (!rst_n) fin_q < FINE_W'(STEPS)); // R3
endmodule

// File: rtl/dpg_trig.sv
module dpg_trig #(
  parameter int SYNC_STAGES = 2,
  parameter int PERIOD_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trig_ext_i,
  input  logic                src_self_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                fire_o,
  output logic                fire_self_o
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;
  logic                   ext_edge;

  logic [PERIOD_W-1:0]    tmr_q, tmr_d;
  logic                   self_en, tmr_wrap;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], trig_ext_i};
    prev_d = sync_q[SYNC_STAGES-1];
  end

  assign ext_edge = sync_q[SYNC_STAGES-1] & ~prev_q;

  always_comb begin
    self_en  = src_self_i && (period_i != '0);
    tmr_wrap = self_en && (tmr_q >= (period_i - PERIOD_W'(1)));
    if (!self_en || tmr_wrap) begin
      tmr_d = '0;
    end else begin
      tmr_d = tmr_q + PERIOD_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      tmr_q  <= '0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
      tmr_q  <= tmr_d;
    end
  end

  assign fire_o      = src_self_i ? tmr_wrap : ext_edge;
  assign fire_self_o = src_self_i;

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ext_edge |=> !ext_edge); // R2
  AST_SELF_OFF: assert property (@(posedge clk) disable iff (!rst_n) (src_self_i && period_i == '0) |-> !fire_o); // R8
endmodule

// File: rtl/dpg_fine_add.sv
module dpg_fine_add #(
  parameter int DELAY_W = 24,
  parameter int STEPS   = 100,
  parameter int FINE_W  = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DELAY_W-1:0] crs_i,
  input  logic [FINE_W-1:0]  fin_i,
  input  logic [FINE_W-1:0]  phase_i,
  input  logic               use_phase_i,
  output logic [DELAY_W-1:0] crs_o,
  output logic [FINE_W-1:0]  fine_o
);
  localparam logic [FINE_W-1:0] PH_MAX  = FINE_W'(STEPS - 1);
  localparam logic [FINE_W:0]   STEPS_S = (FINE_W+1)'(STEPS);

  logic [FINE_W-1:0] phase_eff;
  logic [FINE_W:0]   sum;
  logic [FINE_W:0]   wrapped;
  logic              carry;

  always_comb begin
    if (!use_phase_i) begin
      phase_eff = '0;
    end else if (phase_i > PH_MAX) begin
      phase_eff = PH_MAX;
    end else begin
      phase_eff = phase_i;
    end
    sum     = {1'b0, fin_i} + {1'b0, phase_eff};
    carry   = (sum >= STEPS_S);
    wrapped = carry ? (sum - STEPS_S) : sum;
    fine_o  = wrapped[FINE_W-1:0];
    crs_o   = crs_i + DELAY_W'(carry);
  end

  AST_FINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) fine_o < FINE_W'(STEPS)); // R3
  AST_CARRY_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (crs_o != crs_i) |-> (fine_o < phase_eff)); // R4
endmodule

// File: rtl/dpg_seq.sv
module dpg_seq
  import dpg_pkg::*;
#(
  parameter int DELAY_W = 24,
  parameter int FINE_W  = 7,
  parameter int WIDTH_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire_i,
  input  logic [DELAY_W-1:0] crs_i,
  input  logic [FINE_W-1:0]  fine_i,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               busy_o,
  output logic               pulse_o,
  output logic [FINE_W-1:0]  fine_o
);
  seq_state_e         state_q, state_d;
  logic [DELAY_W-1:0] cnt_q, cnt_d;
  logic [WIDTH_W-1:0] wcnt_q, wcnt_d;
  logic [FINE_W-1:0]  fine_q, fine_d;
  logic               accept;

  assign accept = fire_i && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wcnt_d  = wcnt_q;
    fine_d  = fine_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_COUNT;
          cnt_d   = crs_i + DELAY_W'(1);
          fine_d  = fine_i;
          wcnt_d  = (width_i == '0) ? WIDTH_W'(1) : width_i;
        end
      end
      ST_COUNT: begin
        if (cnt_q == DELAY_W'(1)) begin
          state_d = ST_PULSE;
        end else begin
          cnt_d = cnt_q - DELAY_W'(1);
        end
      end
      ST_PULSE: begin
        if (wcnt_q == WIDTH_W'(1)) begin
          state_d = ST_IDLE;
        end else begin
          wcnt_d = wcnt_q - WIDTH_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wcnt_q  <= '0;
      fine_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wcnt_q  <= wcnt_d;
      fine_q  <= fine_d;
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign pulse_o = (state_q == ST_PULSE);
  assign fine_o  = fine_q;

  AST_FINE_HELD: assert property (@(posedge clk) disable iff (!rst_n) pulse_o |=> $stable(fine_o)); // R11
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (busy_o && fire_i) |=> $stable(fine_o)); // R6
  AST_PULSE_AFTER_COUNT: assert property (@(posedge clk) disable iff (!rst_n) $rose(pulse_o) |-> $past(busy_o)); // R2
endmodule

// File: rtl/dly_pulse_gen.sv
module dly_pulse_gen
  import dpg_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int DELAY_W     = 24,
  parameter int STEPS       = 100,
  parameter int WIDTH_W     = 16,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2,
  parameter int PHASE_W     = $clog2(STEPS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  trig_ext,
  input  logic [PHASE_W-1:0]    trig_phase,
  output logic                  busy,
  output logic                  pulse_out,
  output logic [PHASE_W-1:0]    fine_code
);
  localparam int FINE_W   = PHASE_W;
  localparam int PERIOD_W = DATA_W;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  logic [DELAY_W-1:0]  cfg_crs, adj_crs;
  logic [FINE_W-1:0]   cfg_fin, adj_fine;
  logic [WIDTH_W-1:0]  cfg_width;
  logic [PERIOD_W-1:0] cfg_period;
  logic                cfg_self, fire, fire_self;

  dpg_regs #(
    .DATA_W(DATA_W), .DELAY_W(DELAY_W), .STEPS(STEPS), .FINE_W(FINE_W),
    .WIDTH_W(WIDTH_W), .PERIOD_W(PERIOD_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .crs_o(cfg_crs), .fin_o(cfg_fin), .width_o(cfg_width), .period_o(cfg_period),
    .src_self_o(cfg_self)
  );

  dpg_trig #(
    .SYNC_STAGES(SYNC_STAGES), .PERIOD_W(PERIOD_W)
  ) u_trig (
    .clk(clk), .rst_n(rst_int_n), .trig_ext_i(trig_ext), .src_self_i(cfg_self),
    .period_i(cfg_period), .fire_o(fire), .fire_self_o(fire_self)
  );

  dpg_fine_add #(
    .DELAY_W(DELAY_W), .STEPS(STEPS), .FINE_W(FINE_W)
  ) u_fine (
    .clk(clk), .rst_n(rst_int_n), .crs_i(cfg_crs), .fin_i(cfg_fin),
    .phase_i(trig_phase), .use_phase_i(!fire_self),
    .crs_o(adj_crs), .fine_o(adj_fine)
  );

  dpg_seq #(
    .DELAY_W(DELAY_W), .FINE_W(FINE_W), .WIDTH_W(WIDTH_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_int_n), .fire_i(fire), .crs_i(adj_crs), .fine_i(adj_fine),
    .width_i(cfg_width), .busy_o(busy), .pulse_o(pulse_out), .fine_o(fine_code)
  );
endmodule

// File: tb/dly_pulse_gen_bench.sv
module dly_pulse_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic        trig_ext;
  logic [6:0]  trig_phase;
  logic        busy, pulse_out;
  logic [6:0]  fine_code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dly_pulse_gen u_dly_pulse_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .trig_ext(trig_ext), .trig_phase(trig_phase), .busy(busy), .pulse_out(pulse_out),
    .fine_code(fine_code)
  );

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Fire an external edge and check fine code, coarse count, width and release.
  task automatic run_ext(string tag, int exp_c, int exp_f, int exp_w);
    int n, c, w;
    @(negedge clk);
    trig_ext = 1'b1;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 3) trig_ext = 1'b0;
    end while (!busy && n < 20);
    trig_ext = 1'b0;
    chk({tag, " R2 busy"}, busy, 1);
    chk({tag, " R3 fine"}, fine_code, exp_f);
    c = 0;
    while (!pulse_out && c < 150000) begin @(negedge clk); c++; end
    chk({tag, " R2 coarse"}, c, exp_c + 1);
    w = 0;
    while (pulse_out && w < 70000) begin w++; @(negedge clk); end
    chk({tag, " R5 width"}, w, exp_w);
    chk({tag, " R5 release"}, busy, 0);
    chk({tag, " R11 fine held"}, fine_code, exp_f);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 pulse", pulse_out, 0);
    chk("R1 fine", fine_code, 0);
    trig_phase = 7'd0;
    run_ext("R1 defaults", 0, 0, 1);
  endtask

  task automatic t_basic();
    wr(2'd0, 32'd1234); wr(2'd1, 32'd3);
    trig_phase = 7'd0;  run_ext("R2 plain", 12, 34, 3);
    trig_phase = 7'd70; run_ext("R4 carry", 13, 4, 3);
    wr(2'd0, 32'd50); trig_phase = 7'd10; run_ext("R2 zero coarse", 0, 60, 3);
    wr(2'd0, 32'd99); trig_phase = 7'd99; run_ext("R4 max sum", 1, 98, 3);
    wr(2'd0, 32'd0); trig_phase = 7'd120; run_ext("R10 clamp", 0, 99, 3);
    wr(2'd0, 32'd1234); wr(2'd1, 32'd0); trig_phase = 7'd0;
    run_ext("R5 zero width", 12, 34, 1);
  endtask

  task automatic t_busy();
    int n, c, w, extra;
    wr(2'd0, 32'd2045); wr(2'd1, 32'd2); trig_phase = 7'd0;
    @(negedge clk); trig_ext = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; if (n == 3) trig_ext = 1'b0; end while (!busy && n < 20);
    trig_ext = 1'b0;
    c = 0;
    while (!pulse_out && c < 1000) begin
      @(negedge clk); c++;
      if (c == 4) begin trig_phase = 7'd50; trig_ext = 1'b1; end
      if (c == 6) begin wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'd537; end
      if (c == 7) wr_en = 1'b0;
      if (c == 8) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'd4; trig_ext = 1'b0; end
      if (c == 9) wr_en = 1'b0;
    end
    chk("R6 coarse unchanged", c, 21);
    chk("R6 fine unchanged", fine_code, 45);
    w = 0;
    while (pulse_out && w < 100) begin w++; @(negedge clk); end
    chk("R9 width unchanged", w, 2);
    extra = 0;
    repeat (30) begin @(negedge clk); if (busy) extra++; end
    chk("R6 no second run", extra, 0);
    trig_phase = 7'd0;
    run_ext("R9 new values", 5, 37, 4);
  endtask

  task automatic t_self();
    int k, hits;
    wr(2'd0, 32'd345); wr(2'd1, 32'd2); wr(2'd2, 32'd40);
    trig_phase = 7'd55;
    wr(2'd3, 32'd1);
    k = 0;
    while (busy && k < 200) begin @(negedge clk); k++; end
    k = 0;
    while (!busy && k < 200) begin @(negedge clk); k++; end
    chk("R7 self fires", busy, 1);
    chk("R7 phase ignored", fine_code, 45);
    k = 0;
    do begin @(negedge clk); k++; end while (busy && k < 200);
    while (!busy && k < 200) begin @(negedge clk); k++; end
    chk("R7 period", k, 40);
    wr(2'd2, 32'd0);
    repeat (20) @(negedge clk);
    hits = 0;
    repeat (120) begin @(negedge clk); if (busy) hits++; end
    chk("R8 zero period", hits, 0);
    @(negedge clk); trig_ext = 1'b1;
    repeat (3) @(negedge clk);
    trig_ext = 1'b0;
    hits = 0;
    repeat (30) begin @(negedge clk); if (busy) hits++; end
    chk("R7 external masked", hits, 0);
    wr(2'd2, 32'd40); wr(2'd3, 32'd0);
    hits = 0;
    repeat (120) begin @(negedge clk); if (busy) hits++; end
    chk("R7 timer masked", hits, 0);
  endtask

  task automatic t_long();
    wr(2'd0, 32'd10000000); wr(2'd1, 32'd1); trig_phase = 7'd0;
    run_ext("R12 1 ms", 100000, 0, 1);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 2'd0; wr_data = 32'd0;
    trig_ext = 1'b0; trig_phase = 7'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_busy();
    t_self();
    t_long();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule